// File: doc/BRIEF.md
# Strobe-Clocked Double-Rate Input Capture

This block takes a small group of input pins that carry data on both edges of a forwarded strobe and turns them into two parallel words for the core. One word holds the bits sampled when the strobe rises, and the other holds the bits sampled when it falls. Each lane gets one register for the rising edge and one for the falling edge. The falling-edge sample is then registered again on the next rising strobe edge, so both halves of a pair leave the strobe domain together. The pair then passes through a synchronising stage and a transfer stage before it reaches the system clock domain.

The synchronising stage is clocked by the system clock or by its inverse, chosen at run time. This moves the strobe-to-system handoff by half a clock period, and it shortens the latency by one system cycle when the inverse is chosen. A single-rate mode uses only one capture element. That element can be an edge-triggered flop or a latch that is transparent while the strobe is low. A route select and a tap setting for the input delay are accepted, but they only pick between two zero-delay routes.

Top module: `ddr_in_capture`

## Requirements
- R1: While `rst` is high and sampled on at least two system clock rising edges, both `rise_word` and `fall_word` read zero. `rst` is sampled synchronously on every capture, synchronising and transfer register.
- R2: With `ddr_en`=1, `rise_word` presents the pins as sampled at a rising strobe edge. `fall_word` presents the pins as sampled at the falling strobe edge that follows it. Successive pairs appear in the order they were sent, one per strobe cycle.
- R3: With `sync_inv`=0 and the strobe rising in the first half of each system clock period, a pair whose rising strobe edge lies between system rising edges k and k+1 is presented from system rising edge k+3 in flop capture.
- R4: With `sync_inv`=1 under the same strobe phase, the synchronising stage runs on the falling system clock edge. The same pair is presented from system rising edge k+2, one cycle earlier than with `sync_inv`=0.
- R5: With `ddr_en`=0 and `sdr_latch`=0, `rise_word` presents the pins as sampled at the rising strobe edge, with the latency of R3 or R4, and `fall_word` stays zero.
- R6: With `ddr_en`=0 and `sdr_latch`=1, the first element is a latch that is transparent while the strobe is low and holds while it is high. The value present at rising strobe edge n reaches `rise_word` one system cycle sooner than in R5. `fall_word` stays zero. In `ddr_en`=1, `sdr_latch` has no effect.
- R7: `dly_sel` (0 selects the fixed route, 1 the dynamic route) and `dly_tap` do not change any captured value or its latency.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Forwarded data strobe |
| pin | input | W | Input data lanes |
| dly_sel | input | 1 | Delay route select: 0 fixed, 1 dynamic |
| dly_tap | input | TAP_W | Dynamic delay tap setting |
| ddr_en | input | 1 | 1 captures on both strobe edges, 0 single-rate |
| sdr_latch | input | 1 | Single-rate first element: 0 flop, 1 latch |
| sync_inv | input | 1 | 1 clocks the synchronising stage on the inverted system clock |
| rise_word | output | W | Rising-edge word in the system domain |
| fall_word | output | W | Falling-edge word in the system domain |

## Verification
The assertions check on every cycle that reset clears both output words. They also check that a realigned strobe-domain pair reaches the outputs after exactly two system rising edges when `sync_inv` is 0, and after one falling-then-rising step when it is 1. Finally, they check that `fall_word` stays zero once single-rate mode has settled. The bench scenarios cover what depends on the external strobe phase: pin values appearing at the predicted system cycle, the one-cycle gain of latch capture, the order of pairs, and the absence of any effect from the delay select.

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture #(
  parameter int W     = 4,
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [W-1:0]     pin,
  input  logic             dly_sel,
  input  logic [TAP_W-1:0] dly_tap,
  input  logic             ddr_en,
  input  logic             sdr_latch,
  input  logic             sync_inv,
  output logic [W-1:0]     rise_word,
  output logic [W-1:0]     fall_word
);

  logic [W-1:0] route_fixed, route_dyn, din;
  logic         unused_tap;
  logic [W-1:0] cap_r, cap_l, cap_f, first_s;
  logic [W-1:0] hold_r, hold_f;
  logic [W-1:0] sync_r, sync_f;
  logic         sync_clk;
  logic         use_latch;

  assign route_fixed = pin;
  assign route_dyn   = pin;
  assign din         = dly_sel ? route_dyn : route_fixed;
  assign unused_tap  = ^dly_tap;

  assign use_latch = sdr_latch & ~ddr_en;
  assign sync_clk  = clk ^ sync_inv;

  always_ff @(posedge strobe)
    if (rst) cap_r <= '0;
    else     cap_r <= din;

  always_latch
    if (rst)          cap_l <= '0;
    else if (!strobe) cap_l <= din;

  always_ff @(negedge strobe)
    if (rst) cap_f <= '0;
    else     cap_f <= din;

  assign first_s = use_latch ? cap_l : cap_r;

  always_ff @(posedge strobe)
    if (rst) begin
      hold_r <= '0;
      hold_f <= '0;
    end else begin
      hold_r <= first_s;
      hold_f <= ddr_en ? cap_f : '0;
    end

  always_ff @(posedge sync_clk)
    if (rst) begin
      sync_r <= '0;
      sync_f <= '0;
    end else begin
      sync_r <= hold_r;
      sync_f <= hold_f;
    end

  always_ff @(posedge clk)
    if (rst) begin
      rise_word <= '0;
      fall_word <= '0;
    end else begin
      rise_word <= sync_r;
      fall_word <= sync_f;
    end

endmodule

// File: rtl/ddr_in_capture_chk.sv
`timescale 1ns/1ps
module ddr_in_capture_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ddr_en,
  input logic         sdr_latch,
  input logic         sync_inv,
  input logic [W-1:0] hold_r,
  input logic [W-1:0] hold_f,
  input logic [W-1:0] rise_word,
  input logic [W-1:0] fall_word
);

  logic [2:0] cfg_q    = '0;
  logic [2:0] settle_q = '0;
  logic       rst_q    = 1'b0;

  always_ff @(posedge clk) begin
    cfg_q <= {ddr_en, sdr_latch, sync_inv};
    rst_q <= rst;
    if (rst || cfg_q != {ddr_en, sdr_latch, sync_inv}) settle_q <= '0;
    else if (settle_q != 3'd5)                         settle_q <= settle_q + 3'd1;
    if (rst_q && rst)
      p_reset_clear_r1: assert (rise_word == '0 && fall_word == '0)
        else $error("reset did not clear output words");
  end

  p_true_sync_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (settle_q == 3'd5 && !sync_inv) |-> {rise_word, fall_word} == $past({hold_r, hold_f}, 2));

  p_inv_sync_latency_r4: assert property (@(negedge clk) disable iff (rst)
    (settle_q == 3'd5 && sync_inv) |=> {rise_word, fall_word} == $past({hold_r, hold_f}));

  p_single_rate_fall_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (settle_q == 3'd5 && !ddr_en) |-> fall_word == '0);

endmodule

bind ddr_in_capture ddr_in_capture_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .ddr_en(ddr_en), .sdr_latch(sdr_latch), .sync_inv(sync_inv),
  .hold_r(hold_r), .hold_f(hold_f), .rise_word(rise_word), .fall_word(fall_word)
);

// File: tb/ddr_in_capture_tb_top.sv
`timescale 1ns/1ps
module ddr_in_capture_tb_top;
  localparam int W = 4;
  localparam int TAP_W = 4;

  logic clk = 1'b0, rst = 1'b1, strobe = 1'b0;
  logic dly_sel = 1'b0, ddr_en = 1'b1, sdr_latch = 1'b0, sync_inv = 1'b0;
  logic [W-1:0] pin = '0;
  logic [TAP_W-1:0] dly_tap = '0;
  logic [W-1:0] rise_word, fall_word;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] pos_h [0:255];
  logic [W-1:0] neg_h [0:255];

  always #5 clk = ~clk;

  ddr_in_capture #(.W(W), .TAP_W(TAP_W)) dut_i (
    .clk(clk), .rst(rst), .strobe(strobe), .pin(pin), .dly_sel(dly_sel), .dly_tap(dly_tap),
    .ddr_en(ddr_en), .sdr_latch(sdr_latch), .sync_inv(sync_inv),
    .rise_word(rise_word), .fall_word(fall_word)
  );

  function automatic int lat(bit ddr, bit lm, bit pol);
    int l = pol ? 2 : 3;
    if (!ddr && lm) l = l - 1;
    return l;
  endfunction

  function automatic logic [W-1:0] exp_rise(int n, int l);
    return (n - l < 0) ? '0 : pos_h[n-l];
  endfunction

  function automatic logic [W-1:0] exp_fall(int n, int l, bit ddr);
    return (!ddr || n - l < 0) ? '0 : neg_h[n-l];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_phase(bit ddr, bit lm, bit pol, int ncyc, int pat);
    string base;
    base = ddr ? (pol ? "R2 R4" : "R2 R3") :
           (lm ? (pol ? "R6 R4" : "R6 R3") : (pol ? "R5 R4" : "R5 R3"));
    for (int n = 0; n < 4 + ncyc; n++) begin
      logic [W-1:0] p, q;
      int l;
      string tag;
      @(posedge clk);
      #1;
      if (n == 0) begin
        rst = 1'b1; ddr_en = ddr; sdr_latch = lm; sync_inv = pol;
      end
      if (n == 4) rst = 1'b0;
      if (n < 4) begin
        p = '0; q = '0;
      end else begin
        case (pat)
          1:       begin p = '1; q = '0; end
          2:       begin p = n[0] ? 4'b1010 : 4'b0101; q = ~p; end
          default: begin p = W'($urandom); q = W'($urandom); end
        endcase
      end
      pos_h[n] = p;
      neg_h[n] = q;
      dly_sel = 1'($urandom);
      dly_tap = TAP_W'($urandom);
      pin = p;
      #1.5 strobe = 1'b1;
      #0.5;
      l = lat(ddr, lm, pol);
      tag = dly_sel ? {base, " R7"} : base;
      if (n >= 2 && n < 4) begin
        chk("R1 rise", rise_word, '0);
        chk("R1 fall", fall_word, '0);
      end else if (n >= 4) begin
        chk({tag, " rise"}, rise_word, exp_rise(n, l));
        chk({tag, " fall"}, fall_word, exp_fall(n, l, ddr));
      end
      #3 pin = q;
      #1.5 strobe = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_phase(1'b1, 1'b0, 1'b0, 60, 0);
    run_phase(1'b1, 1'b1, 1'b1, 60, 0);
    run_phase(1'b1, 1'b0, 1'b0, 12, 2);
    run_phase(1'b1, 1'b0, 1'b1, 12, 1);
    run_phase(1'b0, 1'b0, 1'b0, 50, 0);
    run_phase(1'b0, 1'b0, 1'b1, 30, 2);
    run_phase(1'b0, 1'b1, 1'b0, 50, 0);
    run_phase(1'b0, 1'b1, 1'b1, 50, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule